// File: doc/BRIEF.md
# Thermal Sensor Converter Sequencer with Dual-Level Trip Detection

This block controls a converter shared by up to four on-die temperature sensors. Software reaches it through a small register bus. It can start one conversion on a chosen sensor by hand. It can also hand the converter to a free-running scan that samples a set of sensors at a fixed interval. The converter sits outside the block and is reached through a request and done handshake.

Each scanned 12-bit code is checked against two per-sensor limits: a warning limit and a trip limit. The code of such a sensor falls as the die heats, so a limit counts as crossed when the code is at or below it. A crossing must be seen on a set number of back-to-back scan samples before it is recorded as a pending flag. Enabled warning flags drive an interrupt line. An enabled trip flag latches a shutdown line. While any warning is outstanding, the scan runs at a second, usually faster, interval.

Top module: `tsense_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` and `shutdown` are low and no `adc_req` is issued.
- R2: Offsets and fields:
  - Control at 0x00: channel [2:0], power bit 3, start bit 4 (reads 0), busy bit 12.
  - Scan control at 0x04: enable bit 0, channel n enable at bit 4+n, busy bit 16.
  - Enables at 0x08: warning n at bit n, trip n at bit 4+n.
  - Pending at 0x0C, with the same bit layout as the enables.
  - Data at 0x20+4n; warning limits at 0x30+4n; trip limits at 0x40+4n.
  - Warning debounce at 0x60 and trip debounce at 0x64, 4 bits each.
  - Scan interval at 0x68 and hot interval at 0x6C, 16 bits each.
  - Limits and data keep 12 bits; unused upper bits read zero.
- R3: A write to 0x00 with bits 3 and 4 set and a channel below 4 issues one single-cycle `adc_req` on that channel. Bit 12 reads 1 until `adc_done` returns, and the code then appears at 0x20+4n. With bit 3 or bit 4 clear, or with a channel of 4 or more, no conversion starts.
- R4: With the scan enabled, a sweep starts once the interval counter reaches the selected interval. The sweep converts each enabled channel once, in ascending channel order. Bit 16 reads 1 while a sweep is in progress.
- R5: A scan sample exceeds the warning limit when code <= limit. Warning pending bit n sets on the D-th consecutive exceeding sample, where D is the warning debounce and a value of 0 acts as 1. A non-exceeding sample restarts the run, and so does disabling the scan.
- R6: The trip limit of each channel is compared and debounced in the same way, using the trip debounce, and sets pending bit 4+n.
- R7: Writing a 1 to a pending bit clears it and writing a 0 leaves it unchanged. If a set and a clear fall in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some warning pending bit n and warning enable bit n are both 1.
- R9: `shutdown` rises one cycle after a trip pending bit whose trip enable is 1 is first visible. It then stays high until reset, even after that pending bit is cleared.
- R10: While any warning pending bit is set, the scan uses the hot interval at 0x6C in place of the interval at 0x68.
- R11: Codes from hand-started conversions update the data registers but never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| adc_req | output | 1 | One-cycle conversion request |
| adc_ch | output | 3 | Channel of the current conversion |
| adc_done | input | 1 | One-cycle pulse: `adc_code` is valid |
| adc_code | input | 12 | Converted code |
| irq | output | 1 | Enabled warning pending |
| shutdown | output | 1 | Latched thermal trip |

## Verification
A software write that clears a warning pending bit can land in the same clock edge as a scan sample that sets that bit again. The bench sets up this collision with a debounce of one and a warning flag already pending. It watches for `adc_req` and knows the fixed latency of its converter model, so it can time the clearing write to the same edge as `adc_done`. The pending bit must read 1 afterwards. A lone clearing write, made with the scan stopped, must leave the bit 0.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
   localparam int CH_W = 3;

   localparam logic [7:0] OFS_USER  = 8'h00;
   localparam logic [7:0] OFS_SCAN  = 8'h04;
   localparam logic [7:0] OFS_IEN   = 8'h08;
   localparam logic [7:0] OFS_PEND  = 8'h0C;
   localparam logic [7:0] OFS_DATA  = 8'h20;
   localparam logic [7:0] OFS_WTHR  = 8'h30;
   localparam logic [7:0] OFS_TTHR  = 8'h40;
   localparam logic [7:0] OFS_WDB   = 8'h60;
   localparam logic [7:0] OFS_TDB   = 8'h64;
   localparam logic [7:0] OFS_PER   = 8'h68;
   localparam logic [7:0] OFS_HPER  = 8'h6C;

   localparam int B_PWR   = 3;
   localparam int B_GO    = 4;
   localparam int B_UBUSY = 12;
   localparam int B_SEN   = 0;
   localparam int B_SCH   = 4;
   localparam int B_SBUSY = 16;
   localparam int B_TRIP  = 4;

   typedef enum logic {SQ_IDLE, SQ_CONV} sq_state_e;
endpackage

// File: rtl/tsense_dbnc.sv
module tsense_dbnc #(
   parameter int CODE_W = 12,
   parameter int DB_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp_vld,
   input  logic [CODE_W-1:0] smp_code,
   input  logic [CODE_W-1:0] thr,
   input  logic [DB_W-1:0]   need,
   output logic              hit
);
   localparam logic [DB_W-1:0] CNT_MAX = '1;

   logic [DB_W-1:0] cnt, cnt_inc, need_eff;
   logic            exceed;

   assign exceed   = (smp_code <= thr);
   assign cnt_inc  = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
   assign need_eff = (need == '0) ? DB_W'(1) : need;
   assign hit      = smp_vld && exceed && (cnt_inc >= need_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (smp_vld) cnt <= exceed ? cnt_inc : '0;
   end

   // R5 / R6: a sample above the limit ends the run
   p_miss_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && (smp_code > thr)) |=> (cnt == '0));
   // R5 / R6: a flag needs the earlier run length behind it
   p_hit_has_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cnt >= need_eff - 1'b1));
endmodule

// File: rtl/tsense_chan.sv
module tsense_chan #(
   parameter int CODE_W = 12,
   parameter int DB_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp_vld,
   input  logic [CODE_W-1:0] smp_code,
   input  logic [CODE_W-1:0] warn_thr,
   input  logic [CODE_W-1:0] trip_thr,
   input  logic [DB_W-1:0]   warn_db,
   input  logic [DB_W-1:0]   trip_db,
   output logic              warn_hit,
   output logic              trip_hit
);
   tsense_dbnc #(.CODE_W(CODE_W), .DB_W(DB_W)) u_warn (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
      .smp_code(smp_code), .thr(warn_thr), .need(warn_db), .hit(warn_hit));

   tsense_dbnc #(.CODE_W(CODE_W), .DB_W(DB_W)) u_trip (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
      .smp_code(smp_code), .thr(trip_thr), .need(trip_db), .hit(trip_hit));
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
   import tsense_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             user_go,
   input  logic [CH_W-1:0]  user_ch,
   input  logic             scan_en,
   input  logic [NCH-1:0]   scan_mask,
   input  logic [PER_W-1:0] period,
   output logic             adc_req,
   output logic [CH_W-1:0]  adc_ch,
   input  logic             adc_done,
   output logic             res_vld,
   output logic             res_scan,
   output logic [CH_W-1:0]  res_ch,
   output logic             user_busy,
   output logic             scan_busy
);
   sq_state_e        state;
   logic             src_scan, user_pend, req_q;
   logic [CH_W-1:0]  cur_ch, user_ch_q, nxt_ch;
   logic [NCH-1:0]   sweep;
   logic [PER_W-1:0] tmr;
   logic             scan_conv;

   assign scan_conv = (state == SQ_CONV) && src_scan;

   always_comb begin
      nxt_ch = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (sweep[i]) nxt_ch = CH_W'(i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         src_scan  <= 1'b0;
         user_pend <= 1'b0;
         req_q     <= 1'b0;
         cur_ch    <= '0;
         user_ch_q <= '0;
         sweep     <= '0;
         tmr       <= '0;
      end else begin
         req_q <= 1'b0;
         if (user_go && !user_pend && !((state == SQ_CONV) && !src_scan)) begin
            user_pend <= 1'b1;
            user_ch_q <= user_ch;
         end
         case (state)
            SQ_IDLE: begin
               if (user_pend) begin
                  req_q     <= 1'b1;
                  cur_ch    <= user_ch_q;
                  src_scan  <= 1'b0;
                  user_pend <= 1'b0;
                  state     <= SQ_CONV;
               end else if (sweep != '0) begin
                  req_q    <= 1'b1;
                  cur_ch   <= nxt_ch;
                  src_scan <= 1'b1;
                  sweep    <= sweep & ~(NCH'(1) << nxt_ch);
                  state    <= SQ_CONV;
               end
            end
            default: if (adc_done) state <= SQ_IDLE;
         endcase
         if (!scan_en) begin
            tmr   <= '0;
            sweep <= '0;
         end else if ((sweep == '0) && !scan_conv) begin
            if (tmr >= period) begin
               tmr   <= '0;
               sweep <= scan_mask;
            end else begin
               tmr <= tmr + 1'b1;
            end
         end
      end
   end

   assign adc_req   = req_q;
   assign adc_ch    = cur_ch;
   assign res_vld   = (state == SQ_CONV) && adc_done;
   assign res_scan  = src_scan;
   assign res_ch    = cur_ch;
   assign user_busy = user_pend || ((state == SQ_CONV) && !src_scan);
   assign scan_busy = (sweep != '0) || scan_conv;

   p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_req |=> !adc_req);
   p_user_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SQ_CONV) && !src_scan && adc_done) |=> !user_busy);
   p_sweep_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (sweep == '0));
endmodule

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
   import tsense_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int CODE_W = 12,
   parameter int DB_W   = 4,
   parameter int PER_W  = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        adc_req,
   output logic [2:0]  adc_ch,
   input  logic        adc_done,
   input  logic [11:0] adc_code,
   output logic        irq,
   output logic        shutdown
);
   initial begin
      assert (NCH >= 1 && NCH <= 4) else $error("NCH must be 1..4");
      assert (CODE_W == 12) else $error("CODE_W must match the converter port");
      assert (DB_W >= 1 && DB_W <= 8) else $error("DB_W out of range");
      assert (PER_W >= 1 && PER_W <= 16) else $error("PER_W out of range");
   end

   logic              wr_en, user_go, pend_wr;
   logic [CH_W-1:0]   usr_ch;
   logic              usr_pwr, scan_en;
   logic [NCH-1:0]    scan_mask, wen, ten, pend_w, pend_t, hit_w, hit_t;
   logic [CODE_W-1:0] data_q [NCH];
   logic [CODE_W-1:0] wthr   [NCH];
   logic [CODE_W-1:0] tthr   [NCH];
   logic [DB_W-1:0]   wdb, tdb;
   logic [PER_W-1:0]  per, hper, per_sel;
   logic              res_vld, res_scan, user_busy, scan_busy, smp_vld, shut_q;
   logic [CH_W-1:0]   res_ch;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_en   = bus_sel && bus_wr;
   assign pend_wr = wr_en && (bus_addr == OFS_PEND);
   assign user_go = wr_en && (bus_addr == OFS_USER) && bus_wdata[B_GO] &&
                    bus_wdata[B_PWR] && (int'(bus_wdata[CH_W-1:0]) < NCH);
   assign per_sel = (pend_w != '0) ? hper : per;
   assign smp_vld = res_vld && res_scan && scan_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usr_ch <= '0; usr_pwr <= 1'b0; scan_en <= 1'b0; scan_mask <= '0;
         wen <= '0; ten <= '0; pend_w <= '0; pend_t <= '0;
         wdb <= '0; tdb <= '0; per <= '0; hper <= '0; shut_q <= 1'b0;
         for (int i = 0; i < NCH; i++) begin
            data_q[i] <= '0; wthr[i] <= '0; tthr[i] <= '0;
         end
      end else begin
         if (wr_en) begin
            case (bus_addr)
               OFS_USER: begin
                  usr_ch  <= bus_wdata[CH_W-1:0];
                  usr_pwr <= bus_wdata[B_PWR];
               end
               OFS_SCAN: begin
                  scan_en   <= bus_wdata[B_SEN];
                  scan_mask <= bus_wdata[B_SCH +: NCH];
               end
               OFS_IEN: begin
                  wen <= bus_wdata[0 +: NCH];
                  ten <= bus_wdata[B_TRIP +: NCH];
               end
               OFS_WDB:  wdb  <= bus_wdata[DB_W-1:0];
               OFS_TDB:  tdb  <= bus_wdata[DB_W-1:0];
               OFS_PER:  per  <= bus_wdata[PER_W-1:0];
               OFS_HPER: hper <= bus_wdata[PER_W-1:0];
               default: ;
            endcase
         end
         for (int i = 0; i < NCH; i++) begin
            if (wr_en && bus_addr == OFS_WTHR + 8'(4 * i)) wthr[i] <= bus_wdata[CODE_W-1:0];
            if (wr_en && bus_addr == OFS_TTHR + 8'(4 * i)) tthr[i] <= bus_wdata[CODE_W-1:0];
            if (res_vld && res_ch == CH_W'(i))           data_q[i] <= adc_code;
         end
         pend_w <= (pend_w & ~({NCH{pend_wr}} & bus_wdata[0 +: NCH])) | hit_w;
         pend_t <= (pend_t & ~({NCH{pend_wr}} & bus_wdata[B_TRIP +: NCH])) | hit_t;
         shut_q <= shut_q | ((pend_t & ten) != '0);
      end
   end

   tsense_seq #(.NCH(NCH), .PER_W(PER_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .user_go(user_go), .user_ch(bus_wdata[CH_W-1:0]),
      .scan_en(scan_en), .scan_mask(scan_mask), .period(per_sel),
      .adc_req(adc_req), .adc_ch(adc_ch), .adc_done(adc_done),
      .res_vld(res_vld), .res_scan(res_scan), .res_ch(res_ch),
      .user_busy(user_busy), .scan_busy(scan_busy));

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      tsense_chan #(.CODE_W(CODE_W), .DB_W(DB_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .clr(!scan_en),
         .smp_vld(smp_vld && (res_ch == CH_W'(g))), .smp_code(adc_code),
         .warn_thr(wthr[g]), .trip_thr(tthr[g]), .warn_db(wdb), .trip_db(tdb),
         .warn_hit(hit_w[g]), .trip_hit(hit_t[g]));

      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_wr && bus_wdata[g] && !hit_w[g]) |=> !pend_w[g]);
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         hit_w[g] |=> pend_w[g]);
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_USER: begin
            bus_rdata[CH_W-1:0] = usr_ch;
            bus_rdata[B_PWR]    = usr_pwr;
            bus_rdata[B_UBUSY]  = user_busy;
         end
         OFS_SCAN: begin
            bus_rdata[B_SEN]        = scan_en;
            bus_rdata[B_SCH +: NCH] = scan_mask;
            bus_rdata[B_SBUSY]      = scan_busy;
         end
         OFS_IEN: begin
            bus_rdata[0 +: NCH]      = wen;
            bus_rdata[B_TRIP +: NCH] = ten;
         end
         OFS_PEND: begin
            bus_rdata[0 +: NCH]      = pend_w;
            bus_rdata[B_TRIP +: NCH] = pend_t;
         end
         OFS_WDB:  bus_rdata[DB_W-1:0]  = wdb;
         OFS_TDB:  bus_rdata[DB_W-1:0]  = tdb;
         OFS_PER:  bus_rdata[PER_W-1:0] = per;
         OFS_HPER: bus_rdata[PER_W-1:0] = hper;
         default: ;
      endcase
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == OFS_DATA + 8'(4 * i)) bus_rdata[CODE_W-1:0] = data_q[i];
         if (bus_addr == OFS_WTHR + 8'(4 * i)) bus_rdata[CODE_W-1:0] = wthr[i];
         if (bus_addr == OFS_TTHR + 8'(4 * i)) bus_rdata[CODE_W-1:0] = tthr[i];
      end
   end

   assign irq      = (pend_w & wen) != '0;
   assign shutdown = shut_q;

   p_shut_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> shutdown);
   p_shut_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_t & ten) != '0) |=> shutdown);
   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wen == '0) |-> !irq);
endmodule

// File: tb/tsense_ctrl_bench.sv
module tsense_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        adc_req;
   logic [2:0]  adc_ch;
   logic        adc_done;
   logic [11:0] adc_code;
   logic        irq, shutdown;

   logic [11:0] codes [4];
   int conv_cnt [4];
   int total;
   int chlog [16];
   int n_chk = 0, n_fail = 0;
   bit ended = 0;

   initial forever #2 clk = ~clk;

   tsense_ctrl u_tsense_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .adc_req(adc_req), .adc_ch(adc_ch), .adc_done(adc_done), .adc_code(adc_code),
      .irq(irq), .shutdown(shutdown));

   // converter model: fixed latency of three cycles
   initial begin
      int ch;
      adc_done = 1'b0;
      adc_code = '0;
      forever begin
         @(negedge clk);
         if (adc_req === 1'b1) begin
            ch = int'(adc_ch);
            if (total < 16) chlog[total] = ch;
            total++;
            repeat (3) @(negedge clk);
            adc_code = (ch < 4) ? codes[ch] : 12'h000;
            adc_done = 1'b1;
            if (ch < 4) conv_cnt[ch]++;
            @(negedge clk);
            adc_done = 1'b0;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic rd_now(logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wait_cnt(int ch, int n);
      int g = 0;
      do begin @(negedge clk); #1; g++; end while (conv_cnt[ch] < n && g < 20000);
   endtask

   task automatic wait_req();
      int g = 0;
      do begin @(negedge clk); #1; g++; end while (adc_req !== 1'b1 && g < 20000);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_sel = 1'b0; bus_wr = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 4; i++) begin conv_cnt[i] = 0; codes[i] = 12'hFFF; end
      total = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      foreach (chlog[i]) chlog[i] = 0;
      rd(8'h00, v); chk("R1 user ctrl", v, 0);
      rd(8'h04, v); chk("R1 scan ctrl", v, 0);
      rd(8'h0C, v); chk("R1 pending", v, 0);
      rd(8'h30, v); chk("R1 warn limit", v, 0);
      chk("R1 irq", irq, 0);
      chk("R1 shutdown", shutdown, 0);
      repeat (50) @(negedge clk);
      chk("R1 no request", total, 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      do_reset();
      wr(8'h30, 32'hFFFF_FABC); rd(8'h30, v); chk("R2 limit width", v, 32'h0000_0ABC);
      wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk("R2 enable fields", v, 32'h0000_00FF);
      wr(8'h68, 32'h0001_2345); rd(8'h68, v); chk("R2 interval width", v, 32'h0000_2345);
      wr(8'h00, 32'h0000_0009); rd(8'h00, v); chk("R2 user fields", v, 32'h0000_0009);
      repeat (20) @(negedge clk);
      chk("R3 no start bit no request", total, 0);
   endtask

   task automatic t_user();
      logic [31:0] v;
      do_reset();
      codes[2] = 12'h123;
      wr(8'h38, 32'hFFF); wr(8'h08, 32'h04);
      wr(8'h00, 32'h1A);
      rd_now(8'h00, v); chk("R3 busy during conversion", v[12], 1);
      wait_cnt(2, 1);
      rd(8'h28, v); chk("R3 data register", v, 32'h123);
      rd(8'h00, v); chk("R3 busy cleared", v[12], 0);
      chk("R3 single request", total, 1);
      chk("R3 request channel", chlog[0], 2);
      rd(8'h0C, v); chk("R11 no pending from user code", v, 0);
      chk("R11 irq low", irq, 0);
      wr(8'h00, 32'h15);
      wr(8'h00, 32'h12);
      repeat (20) @(negedge clk);
      chk("R3 bad channel or no power ignored", total, 1);
   endtask

   task automatic t_order();
      logic [31:0] v;
      do_reset();
      wr(8'h68, 5);
      wr(8'h04, 32'hA1);
      wait_req();
      rd_now(8'h04, v); chk("R4 scan busy", v[16], 1);
      while (total < 4) @(negedge clk);
      chk("R4 first channel", chlog[0], 1);
      chk("R4 second channel", chlog[1], 3);
      chk("R4 third channel", chlog[2], 1);
      chk("R4 disabled channel skipped", conv_cnt[0], 0);
      wr(8'h04, 0);
      repeat (10) @(negedge clk);
      rd(8'h04, v); chk("R4 busy off", v[16], 0);
   endtask

   task automatic t_debounce();
      logic [31:0] v;
      do_reset();
      wr(8'h30, 32'h800); wr(8'h60, 3); wr(8'h68, 20);
      codes[0] = 12'h700; codes[1] = 12'h900;
      wr(8'h34, 32'h800);
      wr(8'h04, 32'h31);
      wait_cnt(0, 2);
      rd(8'h0C, v); chk("R5 two of three", v, 0);
      wait_cnt(0, 3);
      rd(8'h0C, v); chk("R5 third sample sets", v, 32'h1);
      wr(8'h04, 0);
      wr(8'h0C, 32'hFF);
      for (int i = 0; i < 4; i++) conv_cnt[i] = 0;
      codes[0] = 12'h700;
      wr(8'h04, 32'h11);
      wait_cnt(0, 2); codes[0] = 12'h801;
      wait_cnt(0, 3); codes[0] = 12'h700;
      wait_cnt(0, 5);
      rd(8'h0C, v); chk("R5 miss restarts run", v, 0);
      wait_cnt(0, 6);
      rd(8'h0C, v); chk("R5 set after restart", v, 32'h1);
   endtask

   task automatic t_irq_w1c();
      logic [31:0] v;
      do_reset();
      wr(8'h30, 32'h800); wr(8'h60, 0); wr(8'h68, 10);
      codes[0] = 12'h700;
      wr(8'h04, 32'h11);
      wait_cnt(0, 1);
      wr(8'h04, 0);
      rd(8'h0C, v); chk("R5 debounce zero acts as one", v, 32'h1);
      chk("R8 masked irq", irq, 0);
      wr(8'h08, 32'h01);
      chk("R8 enabled irq", irq, 1);
      wr(8'h0C, 32'h02);
      rd(8'h0C, v); chk("R7 zero bit keeps flag", v, 32'h1);
      wr(8'h0C, 32'h01);
      rd(8'h0C, v); chk("R7 one clears", v, 0);
      chk("R8 irq drops", irq, 0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      do_reset();
      wr(8'h30, 32'h800); wr(8'h60, 1); wr(8'h68, 20); wr(8'h08, 1);
      codes[0] = 12'h700;
      wr(8'h04, 32'h11);
      wait_cnt(0, 1);
      wait_req();
      repeat (2) @(negedge clk);
      wr(8'h0C, 32'h01);
      rd(8'h0C, v); chk("R7 set wins over clear", v[0], 1);
      chk("R8 irq held", irq, 1);
   endtask

   task automatic t_hot();
      logic [31:0] v;
      int snap;
      do_reset();
      wr(8'h30, 32'h800); wr(8'h60, 1); wr(8'h68, 3000); wr(8'h6C, 10);
      codes[0] = 12'h700;
      wr(8'h04, 32'h11);
      wait_cnt(0, 1);
      snap = total;
      repeat (300) @(negedge clk);
      chk("R10 hot interval in use", (total - snap) >= 10, 1);
      codes[0] = 12'h900;
      repeat (20) @(negedge clk);
      wr(8'h0C, 32'h01);
      repeat (20) @(negedge clk);
      rd(8'h0C, v); chk("R10 flag cleared", v, 0);
      snap = total;
      repeat (300) @(negedge clk);
      chk("R10 normal interval back", total - snap, 0);
   endtask

   task automatic t_trip();
      logic [31:0] v;
      do_reset();
      wr(8'h4C, 32'h400); wr(8'h64, 2); wr(8'h68, 10); wr(8'h08, 32'h80);
      codes[3] = 12'h400;
      wr(8'h04, 32'h81);
      wait_cnt(3, 1);
      rd(8'h0C, v); chk("R6 one sample not enough", v, 0);
      chk("R9 shutdown still low", shutdown, 0);
      wait_cnt(3, 2);
      rd(8'h0C, v); chk("R6 equal code trips", v, 32'h80);
      chk("R9 shutdown one cycle later", shutdown, 0);
      @(negedge clk);
      chk("R9 shutdown asserted", shutdown, 1);
      wr(8'h04, 0);
      wr(8'h0C, 32'h80);
      rd(8'h0C, v); chk("R7 trip flag cleared", v, 0);
      chk("R9 shutdown latched", shutdown, 1);
      do_reset();
      chk("R1 reset releases shutdown", shutdown, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_regs();
      t_user();
      t_order();
      t_debounce();
      t_irq_w1c();
      t_collide();
      t_hot();
      t_trip();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule